// File: doc/BRIEF.md
# Counter Control Register Frame

This block is the control frame of a scaled system time counter. An APB slave holds the counter's control bits: run, halt-on-debug, scale enable, interrupt enable and bus-error enable. It also holds one scale increment register for each of the two clock sources, and a read-only status word. The 64-bit count is read and written as two 32-bit halves. The count itself lives in a separate datapath. The frame reads that datapath's value on an input bus and hands it write strobes and data.

Every transfer completes in one access cycle. Two kinds of illegal access are caught: a transfer whose security attribute does not match the frame's own, and a transfer to an offset that decodes to no register. Either one leaves all state untouched, returns zero read data and latches an interrupt-pending flag. The flag drives the interrupt line while interrupts are enabled, and software clears it through a write-only clear location. Only a security mismatch can raise the bus error response, and only while that response is enabled.

A scale register write is refused while the counter is running, unless the build-time override `SCALE_WR_ANY` is set.

Top module: `cnt_ctrl_frame`

## Requirements
- R1: After a synchronous reset the counter is running and the other control bits are 0 (halt-on-debug, scale enable, interrupt enable, bus-error enable). The scale registers hold `SCALE0_INIT` and `SCALE1_INIT`, the pending flag is clear and `irq_o` is low.
- R2: The control word sits at byte offset 0x00, is read/write, and reads back bits [4:0] as written. Bit 0 is run, bit 1 halt-on-debug, bit 2 scale enable, bit 3 interrupt enable and bit 4 bus-error enable. Upper bits read 0.
- R3: The status word at 0x04 is read-only and writes to it are ignored. Bit 0 is the `halted_i` input, bits [2:1] are `clk_sel_i`, bit 3 is "scaling implemented" (`SCALE_IMPL`), bit 4 is "hardware clock switching implemented" (`HWSW_IMPL`), bit 5 is `SCALE_WR_ANY` and bit 6 is the interrupt-pending flag.
- R4: The count's low half is at 0x0C and its high half at 0x10. A legal write pulses `cnt_wr_lo_o` or `cnt_wr_hi_o` in its access cycle, with `cnt_wdata_o` equal to the write data. A legal read returns the matching half of `cnt_value_i`.
- R5: Scale register 0 is at 0x14 and scale register 1 at 0x18. A write to either takes effect only if the run bit is 0 at that time or `SCALE_WR_ANY` is 1. A refused write changes nothing. Both registers read back their value.
- R6: A transfer with `pprot_ns` different from `FRAME_NS` is a security error. It changes no register, returns zero read data, and drives `pslverr` high in the access cycle exactly when the bus-error enable bit is 1.
- R7: A transfer with matching security to a word index of 7 or more, or with `paddr[1:0]` non-zero, is a decode error. It changes no register, returns zero read data and never drives `pslverr`.
- R8: Either error sets the pending flag at the end of its access cycle. `irq_o` equals the pending flag ANDed with the interrupt enable bit.
- R9: Writing with bit 0 set to the write-only location at 0x08 clears the pending flag. Writing with bit 0 clear has no effect, and the location reads 0.
- R10: `pready` is always 1. A legal write takes effect at the clock edge that ends its access cycle, and a setup-phase cycle (`psel` high, `penable` low) changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) / read (0) |
| paddr | input | ADDR_W | APB byte address within the frame |
| pwdata | input | 32 | APB write data |
| pprot_ns | input | 1 | Access security attribute, 1 = non-secure |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, tied high |
| pslverr | output | 1 | APB error response for security mismatch |
| cnt_value_i | input | 64 | Current count from the datapath |
| halted_i | input | 1 | Datapath reports the count is halted on debug |
| clk_sel_i | input | 2 | Clock source currently selected |
| cnt_wr_lo_o | output | 1 | Strobe: load low count half |
| cnt_wr_hi_o | output | 1 | Strobe: load high count half |
| cnt_wdata_o | output | 32 | Data for the count half being loaded |
| run_o | output | 1 | Counter run enable |
| hdbg_o | output | 1 | Halt-on-debug enable |
| scale_en_o | output | 1 | Scaling enable |
| scale0_o | output | 32 | Scale increment for clock source 0 (8.24 fixed point) |
| scale1_o | output | 32 | Scale increment for clock source 1 (8.24 fixed point) |
| irq_o | output | 1 | Error interrupt |

## Verification
Read data, `pslverr`, `pready` and the count write strobes are combinational in the access cycle. The bench samples them one nanosecond after the falling edge that raises `penable`, before the edge that ends the transfer. The control outputs, the scale outputs, the pending flag and `irq_o` change at the rising edge that ends the access cycle. They are compared one nanosecond after that edge, against a bench model updated with the transfer's effect. A setup-only cycle is checked one edge later, to confirm nothing moved.

// File: rtl/cfr_pkg.sv
// Package: shared register indices, control-word layout and sizes for the
// counter control frame. Assumes 32-bit registers on word-aligned offsets.
package cfr_pkg;
    localparam int REG_W     = 32;
    localparam int NUM_SCALE = 2;
    localparam int NUM_REGS  = 7;

    // Word indices of the decoded registers (byte offset = index * 4)
    localparam int IX_CTRL = 0;
    localparam int IX_STAT = 1;
    localparam int IX_ICLR = 2;
    localparam int IX_CLO  = 3;
    localparam int IX_CHI  = 4;
    localparam int IX_SC0  = 5;

    // Control word, bit 0 = run ... bit 4 = bus-error enable
    typedef struct packed {
        logic slv_en;
        logic irq_en;
        logic scl_en;
        logic hdbg;
        logic run;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);
    localparam ctl_t CTL_RESET = '{slv_en: 1'b0, irq_en: 1'b0, scl_en: 1'b0,
                                   hdbg: 1'b0, run: 1'b1};
endpackage

// File: rtl/cfr_decode.sv
// Module: address and security decode for one APB transfer.
// Flags a security mismatch first; only a security-clean transfer can be a
// decode error. Produces a one-hot register select for legal transfers.
// Assumes a single outstanding transfer (APB).
module cfr_decode #(
    parameter int ADDR_W   = 12,
    parameter bit FRAME_NS = 1'b0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         psel,
    input  logic                         penable,
    input  logic [ADDR_W-1:0]            paddr,
    input  logic                         pprot_ns,
    output logic                         sec_err_o,
    output logic                         dec_err_o,
    output logic [cfr_pkg::NUM_REGS-1:0] sel_o
);
    import cfr_pkg::*;
    localparam int WORD_W = ADDR_W - 2;

    logic              xfer;
    logic              hit;
    logic              legal;
    logic [WORD_W-1:0] word;

    // Classify the access-phase transfer
    always_comb begin
        xfer      = psel && penable;
        word      = paddr[ADDR_W-1:2];
        hit       = (paddr[1:0] == 2'b00) && (word < WORD_W'(NUM_REGS));
        sec_err_o = xfer && (pprot_ns != FRAME_NS);
        dec_err_o = xfer && !sec_err_o && !hit;
        legal     = xfer && !sec_err_o && hit;
    end

    // One select line per decoded register
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
        assign sel_o[i] = legal && (word == WORD_W'(i));
    end

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_o)); // R2
    AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(sec_err_o && dec_err_o)); // R7
    AST_ERR_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_err_o || dec_err_o) |-> (sel_o == '0)); // R6
endmodule

// File: rtl/cfr_regs.sv
// Module: control word, scale registers, read-back mux and count strobes.
// Assumes sel_i is one-hot and only asserted for legal access-phase
// transfers. Scale writes are gated by the run bit unless SCALE_WR_ANY.
module cfr_regs #(
    parameter bit          SCALE_WR_ANY = 1'b0,
    parameter bit          SCALE_IMPL   = 1'b1,
    parameter bit          HWSW_IMPL    = 1'b0,
    parameter logic [31:0] SCALE0_INIT  = 32'h0100_0000,
    parameter logic [31:0] SCALE1_INIT  = 32'h0100_0000
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [cfr_pkg::NUM_REGS-1:0] sel_i,
    input  logic                         pwrite,
    input  logic [cfr_pkg::REG_W-1:0]    pwdata,
    input  logic [63:0]                  cnt_value_i,
    input  logic                         halted_i,
    input  logic [1:0]                   clk_sel_i,
    input  logic                         pend_i,
    output cfr_pkg::ctl_t                ctl_o,
    output logic [cfr_pkg::NUM_SCALE-1:0][cfr_pkg::REG_W-1:0] scale_o,
    output logic [cfr_pkg::REG_W-1:0]    rdata_o,
    output logic                         cnt_wr_lo_o,
    output logic                         cnt_wr_hi_o,
    output logic                         clr_req_o
);
    import cfr_pkg::*;

    ctl_t ctl_q;
    logic scale_ok;
    logic [REG_W-1:0] stat_w;

    // Control word: reset to running, loaded by a legal write
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_q <= CTL_RESET;
        else if (sel_i[IX_CTRL] && pwrite)
            ctl_q <= ctl_t'(pwdata[CTL_W-1:0]);
    end

    assign scale_ok = SCALE_WR_ANY || !ctl_q.run;

    // One scale register per clock source
    for (genvar i = 0; i < NUM_SCALE; i++) begin : g_scale
        localparam logic [REG_W-1:0] INIT = (i == 0) ? SCALE0_INIT : SCALE1_INIT;
        logic [REG_W-1:0] sc_q;
        // Scale increment: load only when the run gate allows
        always_ff @(posedge clk) begin
            if (!rst_n)
                sc_q <= INIT;
            else if (sel_i[IX_SC0+i] && pwrite && scale_ok)
                sc_q <= pwdata;
        end
        assign scale_o[i] = sc_q;
    end

    // Status word assembly
    always_comb begin
        stat_w    = '0;
        stat_w[0] = halted_i;
        stat_w[2:1] = clk_sel_i;
        stat_w[3] = SCALE_IMPL;
        stat_w[4] = HWSW_IMPL;
        stat_w[5] = SCALE_WR_ANY;
        stat_w[6] = pend_i;
    end

    // Read-back mux; unselected and write-only locations give zero
    always_comb begin
        rdata_o = '0;
        if (!pwrite) begin
            if (sel_i[IX_CTRL]) rdata_o = REG_W'(ctl_q);
            if (sel_i[IX_STAT]) rdata_o = stat_w;
            if (sel_i[IX_CLO])  rdata_o = cnt_value_i[31:0];
            if (sel_i[IX_CHI])  rdata_o = cnt_value_i[63:32];
            for (int k = 0; k < NUM_SCALE; k++)
                if (sel_i[IX_SC0+k]) rdata_o = scale_o[k];
        end
    end

    // Strobes towards the count datapath and the pending-flag clear
    always_comb begin
        cnt_wr_lo_o = sel_i[IX_CLO] && pwrite;
        cnt_wr_hi_o = sel_i[IX_CHI] && pwrite;
        clr_req_o   = sel_i[IX_ICLR] && pwrite && pwdata[0];
    end

    assign ctl_o = ctl_q;

    AST_SCALE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.run && !SCALE_WR_ANY) |=> $stable(scale_o)); // R5
    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == '0) |=> $stable(ctl_q)); // R10
    AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (pwrite || sel_i == '0) |-> (rdata_o == '0)); // R7
endmodule

// File: rtl/cfr_err.sv
// Module: error collection. Latches an interrupt-pending flag on any
// illegal access, clears it on request, gates the interrupt line and
// the bus error response. Assumes errors and clear never coincide in
// one transfer; if they did, set wins.
module cfr_err (
    input  logic clk,
    input  logic rst_n,
    input  logic sec_err_i,
    input  logic dec_err_i,
    input  logic clr_req_i,
    input  logic irq_en_i,
    input  logic slv_en_i,
    output logic pend_o,
    output logic irq_o,
    output logic pslverr_o
);
    logic pend_q;

    // Pending flag: set by an error, cleared by an explicit request
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (sec_err_i || dec_err_i)
            pend_q <= 1'b1;
        else if (clr_req_i)
            pend_q <= 1'b0;
    end

    // Output gating for interrupt and bus error response
    always_comb begin
        pend_o    = pend_q;
        irq_o     = pend_q && irq_en_i;
        pslverr_o = sec_err_i && slv_en_i;
    end

    AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_err_i || dec_err_i) |=> pend_q); // R8
    AST_PEND_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req_i && !sec_err_i && !dec_err_i) |=> !pend_q); // R9
    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !clr_req_i) |=> pend_q); // R8
    AST_DECERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        dec_err_i |-> !pslverr_o); // R7
endmodule

// File: rtl/cnt_ctrl_frame.sv
// Module: APB control frame of the scaled time counter. Zero-wait-state
// slave: read data and error response are combinational in the access
// cycle, register updates land on the edge that ends it. The count itself
// is held in an external datapath reached via cnt_* ports.
module cnt_ctrl_frame #(
    parameter int          ADDR_W       = 12,
    parameter bit          FRAME_NS     = 1'b0,
    parameter bit          SCALE_WR_ANY = 1'b0,
    parameter bit          SCALE_IMPL   = 1'b1,
    parameter bit          HWSW_IMPL    = 1'b0,
    parameter logic [31:0] SCALE0_INIT  = 32'h0100_0000,
    parameter logic [31:0] SCALE1_INIT  = 32'h0100_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    input  logic              pprot_ns,
    output logic [31:0]       prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic [63:0]       cnt_value_i,
    input  logic              halted_i,
    input  logic [1:0]        clk_sel_i,
    output logic              cnt_wr_lo_o,
    output logic              cnt_wr_hi_o,
    output logic [31:0]       cnt_wdata_o,
    output logic              run_o,
    output logic              hdbg_o,
    output logic              scale_en_o,
    output logic [31:0]       scale0_o,
    output logic [31:0]       scale1_o,
    output logic              irq_o
);
    import cfr_pkg::*;

    logic                              sec_err;
    logic                              dec_err;
    logic [NUM_REGS-1:0]               sel;
    logic                              pend;
    logic                              clr_req;
    ctl_t                              ctl;
    logic [NUM_SCALE-1:0][REG_W-1:0]   scale;

    cfr_decode #(.ADDR_W(ADDR_W), .FRAME_NS(FRAME_NS)) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .psel      (psel),
        .penable   (penable),
        .paddr     (paddr),
        .pprot_ns  (pprot_ns),
        .sec_err_o (sec_err),
        .dec_err_o (dec_err),
        .sel_o     (sel)
    );

    cfr_regs #(
        .SCALE_WR_ANY (SCALE_WR_ANY),
        .SCALE_IMPL   (SCALE_IMPL),
        .HWSW_IMPL    (HWSW_IMPL),
        .SCALE0_INIT  (SCALE0_INIT),
        .SCALE1_INIT  (SCALE1_INIT)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_i       (sel),
        .pwrite      (pwrite),
        .pwdata      (pwdata),
        .cnt_value_i (cnt_value_i),
        .halted_i    (halted_i),
        .clk_sel_i   (clk_sel_i),
        .pend_i      (pend),
        .ctl_o       (ctl),
        .scale_o     (scale),
        .rdata_o     (prdata),
        .cnt_wr_lo_o (cnt_wr_lo_o),
        .cnt_wr_hi_o (cnt_wr_hi_o),
        .clr_req_o   (clr_req)
    );

    cfr_err u_err (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_err_i (sec_err),
        .dec_err_i (dec_err),
        .clr_req_i (clr_req),
        .irq_en_i  (ctl.irq_en),
        .slv_en_i  (ctl.slv_en),
        .pend_o    (pend),
        .irq_o     (irq_o),
        .pslverr_o (pslverr)
    );

    // Port fan-out of control state
    always_comb begin
        pready      = 1'b1;
        cnt_wdata_o = pwdata;
        run_o       = ctl.run;
        hdbg_o      = ctl.hdbg;
        scale_en_o  = ctl.scl_en;
        scale0_o    = scale[0];
        scale1_o    = scale[1];
    end

    AST_SEC_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && pprot_ns != FRAME_NS) |=>
        ($stable(run_o) && $stable(scale_en_o) && $stable(scale0_o) && $stable(scale1_o))); // R6
    AST_SEC_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (pprot_ns != FRAME_NS) |-> (!cnt_wr_lo_o && !cnt_wr_hi_o && prdata == '0)); // R6
    AST_SETUP_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !penable) |=> ($stable(run_o) && $stable(hdbg_o) && $stable(scale0_o))); // R10
    AST_PSLVERR_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        pslverr |-> (psel && penable && pprot_ns != FRAME_NS)); // R6
endmodule

// File: tb/cnt_ctrl_frame_bench.sv
// Bench: directed corner cases then seeded random APB traffic, each
// transfer checked against a bench model of the register frame.
module cnt_ctrl_frame_bench;
    localparam logic [31:0] SC0_INIT = 32'h0100_0000;
    localparam logic [31:0] SC1_INIT = 32'h0100_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0, pprot_ns = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic [63:0] cnt_value_i = 64'h0123_4567_89ab_cdef;
    logic        halted_i = 1'b0;
    logic [1:0]  clk_sel_i = 2'b01;
    logic        cnt_wr_lo_o, cnt_wr_hi_o;
    logic [31:0] cnt_wdata_o;
    logic        run_o, hdbg_o, scale_en_o, irq_o;
    logic [31:0] scale0_o, scale1_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Bench model
    logic [4:0]  m_ctl;
    logic [31:0] m_sc0, m_sc1;
    logic        m_pend;

    always #2 clk = ~clk;

    cnt_ctrl_frame u_cnt_ctrl_frame (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .pprot_ns(pprot_ns),
        .prdata(prdata), .pready(pready), .pslverr(pslverr),
        .cnt_value_i(cnt_value_i), .halted_i(halted_i), .clk_sel_i(clk_sel_i),
        .cnt_wr_lo_o(cnt_wr_lo_o), .cnt_wr_hi_o(cnt_wr_hi_o),
        .cnt_wdata_o(cnt_wdata_o), .run_o(run_o), .hdbg_o(hdbg_o),
        .scale_en_o(scale_en_o), .scale0_o(scale0_o), .scale1_o(scale1_o),
        .irq_o(irq_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input int idx);
        case (idx)
            0: return {27'b0, m_ctl};
            1: return {25'b0, m_pend, 1'b0, 1'b0, 1'b1, clk_sel_i, halted_i};
            3: return cnt_value_i[31:0];
            4: return cnt_value_i[63:32];
            5: return m_sc0;
            6: return m_sc1;
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk_state(input string tag);
        chk({tag, " R2 run"},   run_o,      m_ctl[0]);
        chk({tag, " R2 hdbg"},  hdbg_o,     m_ctl[1]);
        chk({tag, " R2 scl"},   scale_en_o, m_ctl[2]);
        chk({tag, " R5 sc0"},   scale0_o,   m_sc0);
        chk({tag, " R5 sc1"},   scale1_o,   m_sc1);
        chk({tag, " R8 irq"},   irq_o,      m_pend && m_ctl[3]);
    endtask

    // One APB transfer: setup, access (sample comb results), edge, check state
    task automatic xfer(input bit wr, input logic [11:0] addr, input logic [31:0] data,
                        input bit ns, input string tag);
        int  idx  = int'(addr[11:2]);
        bit  sec  = ns;
        bit  dec  = !sec && (idx >= 7 || addr[1:0] != 2'b00);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = addr;
        pwdata = data; pprot_ns = ns;
        @(negedge clk);
        penable = 1'b1;
        #1;
        chk({tag, " R10 pready"}, pready, 1'b1);
        chk({tag, " R6 R7 pslverr"}, pslverr, sec && m_ctl[4]);
        if (!wr)
            chk({tag, " R3 R4 R6 R7 rdata"}, prdata, (sec || dec) ? 32'h0 : exp_read(idx));
        chk({tag, " R4 wr_lo"}, cnt_wr_lo_o, wr && !sec && !dec && idx == 3);
        chk({tag, " R4 wr_hi"}, cnt_wr_hi_o, wr && !sec && !dec && idx == 4);
        if (wr && !sec && !dec && (idx == 3 || idx == 4))
            chk({tag, " R4 wdata"}, cnt_wdata_o, data);
        @(posedge clk);
        #1;
        if (sec || dec) m_pend = 1'b1;
        else if (wr) begin
            case (idx)
                0: m_ctl = data[4:0];
                2: if (data[0]) m_pend = 1'b0;
                5: if (!m_ctl[0]) m_sc0 = data;
                6: if (!m_ctl[0]) m_sc1 = data;
                default: ;
            endcase
        end
        psel = 1'b0; penable = 1'b0;
        chk_state(tag);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        m_ctl = 5'b00001; m_sc0 = SC0_INIT; m_sc1 = SC1_INIT; m_pend = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk_state("R1 reset");

        // R2: control readback
        xfer(1'b0, 12'h000, 32'h0, 1'b0, "R2 rd ctrl");
        xfer(1'b1, 12'h000, 32'hffff_ffe7, 1'b0, "R2 wr ctrl");
        xfer(1'b0, 12'h000, 32'h0, 1'b0, "R2 rd ctrl2");
        // R5: scale refused while running
        xfer(1'b1, 12'h014, 32'h0280_0000, 1'b0, "R5 sc0 locked");
        xfer(1'b1, 12'h000, 32'h0000_0000, 1'b0, "R2 stop");
        xfer(1'b1, 12'h014, 32'h0280_0000, 1'b0, "R5 sc0 open");
        xfer(1'b1, 12'h018, 32'h00ab_cdef, 1'b0, "R5 sc1 open");
        xfer(1'b0, 12'h018, 32'h0, 1'b0, "R5 rd sc1");
        // R3: status read, write ignored
        xfer(1'b1, 12'h004, 32'hffff_ffff, 1'b0, "R3 wr stat");
        halted_i = 1'b1; clk_sel_i = 2'b10;
        xfer(1'b0, 12'h004, 32'h0, 1'b0, "R3 rd stat");
        // R4: count halves
        xfer(1'b1, 12'h00c, 32'h1111_2222, 1'b0, "R4 wr lo");
        xfer(1'b1, 12'h010, 32'h3333_4444, 1'b0, "R4 wr hi");
        xfer(1'b0, 12'h010, 32'h0, 1'b0, "R4 rd hi");
        // R6: security mismatch without and with bus error enable
        xfer(1'b1, 12'h000, 32'h1f, 1'b1, "R6 sec noslv");
        xfer(1'b1, 12'h000, 32'h18, 1'b0, "R8 en irq+slv");
        xfer(1'b1, 12'h002 << 2, 32'h1, 1'b0, "R9 clr");
        xfer(1'b1, 12'h014, 32'h0777_0000, 1'b1, "R6 sec slv");
        xfer(1'b0, 12'h00c, 32'h0, 1'b1, "R6 sec rd");
        // R9: clear with bit0 low has no effect, then real clear
        xfer(1'b1, 12'h008, 32'hffff_fffe, 1'b0, "R9 noclr");
        xfer(1'b0, 12'h008, 32'h0, 1'b0, "R9 rd iclr");
        xfer(1'b1, 12'h008, 32'h1, 1'b0, "R9 clr2");
        // R7: undecoded and misaligned
        xfer(1'b0, 12'h01c, 32'h0, 1'b0, "R7 undec rd");
        xfer(1'b1, 12'h002, 32'h0, 1'b0, "R7 misalign");
        xfer(1'b1, 12'hffc, 32'h0, 1'b0, "R7 top");

        // R10: setup-only cycle changes nothing
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 12'h000;
        pwdata = 32'h0000_0001; pprot_ns = 1'b0;
        @(posedge clk); #1;
        psel = 1'b0;
        chk_state("R10 setup only");

        // Random traffic
        for (int n = 0; n < 600; n++) begin
            logic [11:0] a;
            a = {($urandom % 10) == 9 ? 10'($urandom) : 10'($urandom % 9), 2'b00};
            if (($urandom % 16) == 0) a[1:0] = 2'($urandom);
            cnt_value_i = {$urandom, $urandom};
            halted_i    = 1'($urandom);
            clk_sel_i   = 2'($urandom);
            xfer(1'($urandom), a, $urandom, ($urandom % 5) == 0, "RND");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule